// File: doc/BRIEF.md
# Write Streaming Allocation Controller

This block sits beside a cache's write-allocate path and, for every write request that would normally allocate a line, decides where that line may be placed: in the first-level cache, in the second-level cache only, or in neither. It recognises a streaming pattern, which is a run of full-line writes to ascending, adjacent line addresses. It counts how long the run is and stops allocation once the run grows past programmable limits.

Two independent 2-bit threshold codes set the limits. One code bounds first-level allocation only. The other bounds allocation at both levels. Each code has one value that turns its limit off. The decision for a request is registered and appears one cycle after the request, together with a valid flag. The threshold codes come from a configuration register outside this block.

Top module: `wsa_alloc_ctrl`

## Requirements
- R1: `outValid` is high in the cycle after a cycle with `reqValid` high, and low in the cycle after a cycle with `reqValid` low. Idle cycles between requests neither break nor extend a run.
- R2: When `outValid` is low, `allocL1` and `allocL2` are both low.
- R3: `allocL1` is never high while `allocL2` is low. Once the both-levels limit is reached, a line allocates nowhere.
- R4: A request with `fullLine` low allocates in both levels and sets the run length to zero.
- R5: The both-levels code `l2Code` selects the limit: 2'b00 gives 16 lines, 2'b01 gives 128, and 2'b10 gives 512. A line whose run position (counting itself) is at or above the limit has `allocL1` and `allocL2` both low.
- R6: The first-level code `l1Code` selects the limit: 2'b00 gives 4 lines, 2'b01 gives 64, and 2'b10 gives 128. A line at or above that position has `allocL1` low, and `allocL2` still follows R5.
- R7: Code 2'b11 disables its limit. With `l2Code` = 2'b11, `allocL2` is always high on valid output. With both codes at 2'b11, `allocL1` is high as well.
- R8: A full-line write whose `lineAddr` is exactly one greater than the previous full-line write in the same run extends the run. Any other full-line write starts a new run at position 1. A gap, a repeated address or a lower address each start a new run.
- R9: The run length saturates at 512, so a run of any length stays suppressed and never wraps back to allocating.
- R10: A change to either code applies from the next request and does not clear the run length.
- R11: A synchronous, active-high `rst` forces all outputs low and forgets the run and the stored address. The first full-line write after reset is at position 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | A write-allocate request is present this cycle |
| lineAddr | input | ADDR_W | Cache-line address of the request |
| fullLine | input | 1 | The request writes the whole line |
| l1Code | input | 2 | First-level-only streaming limit code |
| l2Code | input | 2 | Both-levels streaming limit code |
| outValid | output | 1 | Decision for the previous cycle's request is present |
| allocL1 | output | 1 | Line may allocate in the first-level cache |
| allocL2 | output | 1 | Line may allocate in the second-level cache |

## Verification
The checker watches properties that hold on every cycle: the one-cycle relation between request and decision valid, quiet flags when there is no decision, the rule that first-level allocation implies second-level allocation, unconditional allocation for partial-line writes, and the effect of the disable codes. The exact line positions at which each limit takes effect can only be shown by the bench's scenarios. The same holds for run restarts on gaps and partial writes, saturation on a run longer than 1024 lines, code changes during a run, and the forgetting of a run across reset. The bench checks these against its own model of the run length.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  // Strobes from the control to the run-tracking datapath
  typedef struct packed {
    logic loadAddr;   // remember this line address as run tail
    logic dropAddr;   // forget the run tail
    logic stepRun;    // extend the run by one line
    logic startRun;   // begin a new run at position 1
    logic clearRun;   // no run in progress
  } runStrobes_t;

  localparam logic [1:0] CODE_OFF = 2'b11;

  // Both-levels limit in lines for a code
  function automatic logic [31:0] bothLimit(input logic [1:0] code);
    case (code)
      2'b00:   bothLimit = 32'd16;
      2'b01:   bothLimit = 32'd128;
      default: bothLimit = 32'd512;
    endcase
  endfunction

  // First-level limit in lines for a code
  function automatic logic [31:0] nearLimit(input logic [1:0] code);
    case (code)
      2'b00:   nearLimit = 32'd4;
      2'b01:   nearLimit = 32'd64;
      default: nearLimit = 32'd128;
    endcase
  endfunction

endpackage

// File: rtl/wsa_datapath.sv
module wsa_datapath
  import wsa_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int CNT_SAT = 512,
  localparam int CNT_W  = $clog2(CNT_SAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lineAddr,
  input  runStrobes_t       strb,
  output logic              isNext,
  output logic [CNT_W-1:0]  nextCount
);

  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(CNT_SAT);

  logic [ADDR_W-1:0] lastAddr;
  logic              lastValid;
  logic [CNT_W-1:0]  runCount;

  assign isNext = lastValid && (lineAddr == lastAddr + ADDR_W'(1));

  always_comb begin
    nextCount = runCount;
    if (strb.clearRun)      nextCount = '0;
    else if (strb.startRun) nextCount = CNT_W'(1);
    else if (strb.stepRun)  nextCount = (runCount >= SAT_VAL) ? SAT_VAL : runCount + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastAddr  <= '0;
      lastValid <= 1'b0;
      runCount  <= '0;
    end else begin
      runCount <= nextCount;
      if (strb.loadAddr) begin
        lastAddr  <= lineAddr;
        lastValid <= 1'b1;
      end else if (strb.dropAddr) begin
        lastValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wsa_control.sv
module wsa_control
  import wsa_pkg::*;
#(
  parameter int CNT_SAT = 512,
  localparam int CNT_W  = $clog2(CNT_SAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             fullLine,
  input  logic [1:0]       l1Code,
  input  logic [1:0]       l2Code,
  input  logic             isNext,
  input  logic [CNT_W-1:0] nextCount,
  output runStrobes_t      strb,
  output logic             outValid,
  output logic             allocL1,
  output logic             allocL2
);

  logic [31:0] runLen;
  logic        stopBoth;
  logic        stopNear;

  always_comb begin
    strb = '0;
    if (reqValid) begin
      if (fullLine) begin
        strb.loadAddr = 1'b1;
        if (isNext) strb.stepRun  = 1'b1;
        else        strb.startRun = 1'b1;
      end else begin
        strb.clearRun = 1'b1;
        strb.dropAddr = 1'b1;
      end
    end
  end

  assign runLen   = 32'(nextCount);
  assign stopBoth = (l2Code != CODE_OFF) && (runLen >= bothLimit(l2Code));
  assign stopNear = stopBoth || ((l1Code != CODE_OFF) && (runLen >= nearLimit(l1Code)));

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      allocL1  <= 1'b0;
      allocL2  <= 1'b0;
    end else begin
      outValid <= reqValid;
      allocL2  <= reqValid && !stopBoth;
      allocL1  <= reqValid && !stopNear;
    end
  end

endmodule

// File: rtl/wsa_alloc_ctrl.sv
module wsa_alloc_ctrl
  import wsa_pkg::*;
#(
  parameter int ADDR_W  = 40,
  parameter int CNT_SAT = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] lineAddr,
  input  logic              fullLine,
  input  logic [1:0]        l1Code,
  input  logic [1:0]        l2Code,
  output logic              outValid,
  output logic              allocL1,
  output logic              allocL2
);

  localparam int CNT_W = $clog2(CNT_SAT + 1);

  runStrobes_t      strb;
  logic             isNext;
  logic [CNT_W-1:0] nextCount;

  wsa_datapath #(.ADDR_W(ADDR_W), .CNT_SAT(CNT_SAT)) u_dp (
    .clk(clk), .rst(rst), .lineAddr(lineAddr), .strb(strb),
    .isNext(isNext), .nextCount(nextCount)
  );

  wsa_control #(.CNT_SAT(CNT_SAT)) u_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .fullLine(fullLine),
    .l1Code(l1Code), .l2Code(l2Code), .isNext(isNext), .nextCount(nextCount),
    .strb(strb), .outValid(outValid), .allocL1(allocL1), .allocL2(allocL2)
  );

endmodule

// File: rtl/wsa_checker.sv
module wsa_checker (
  input logic       clk,
  input logic       rst,
  input logic       reqValid,
  input logic       fullLine,
  input logic [1:0] l1Code,
  input logic [1:0] l2Code,
  input logic       outValid,
  input logic       allocL1,
  input logic       allocL2
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> outValid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !outValid);
  a_r2_quiet_flags: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (!allocL1 && !allocL2));
  a_r3_near_needs_far: assert property (@(posedge clk) disable iff (rst)
    allocL1 |-> allocL2);
  a_r4_partial_allocates: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !fullLine) |=> (allocL1 && allocL2));
  a_r7_both_off: assert property (@(posedge clk) disable iff (rst)
    (reqValid && l2Code == 2'b11) |=> allocL2);
  a_r7_all_off: assert property (@(posedge clk) disable iff (rst)
    (reqValid && l2Code == 2'b11 && l1Code == 2'b11) |=> allocL1);
  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!outValid && !allocL1 && !allocL2));

endmodule

bind wsa_alloc_ctrl wsa_checker u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .fullLine(fullLine),
  .l1Code(l1Code), .l2Code(l2Code), .outValid(outValid),
  .allocL1(allocL1), .allocL2(allocL2)
);

// File: tb/wsa_alloc_ctrl_bench.sv
module wsa_alloc_ctrl_bench;

  localparam int ADDR_W = 40;

  logic              clk = 1'b0;
  logic              rst;
  logic              reqValid;
  logic [ADDR_W-1:0] lineAddr;
  logic              fullLine;
  logic [1:0]        l1Code;
  logic [1:0]        l2Code;
  logic              outValid;
  logic              allocL1;
  logic              allocL2;

  wsa_alloc_ctrl #(.ADDR_W(ADDR_W)) u_wsa_alloc_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .lineAddr(lineAddr),
    .fullLine(fullLine), .l1Code(l1Code), .l2Code(l2Code),
    .outValid(outValid), .allocL1(allocL1), .allocL2(allocL2)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic  l1;
    logic  l2;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model of the run
  logic [ADDR_W-1:0] mLast;
  bit                mLastOk;
  int                mRun;

  function automatic int limBoth(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 128 : 512;
  endfunction
  function automatic int limNear(input logic [1:0] c);
    return (c == 2'b00) ? 4 : (c == 2'b01) ? 64 : 128;
  endfunction

  task automatic modelReset();
    mLastOk = 1'b0;
    mLast   = '0;
    mRun    = 0;
  endtask

  task automatic sendReq(input logic [ADDR_W-1:0] a, input bit full, input string tag);
    expItem_t it;
    bit stopB, stopN;
    if (full) begin
      if (mLastOk && a == mLast + 1) mRun = (mRun >= 512) ? 512 : mRun + 1;
      else mRun = 1;
      mLast = a;
      mLastOk = 1'b1;
    end else begin
      mRun = 0;
      mLastOk = 1'b0;
    end
    stopB = (l2Code != 2'b11) && (mRun >= limBoth(l2Code));
    stopN = stopB || ((l1Code != 2'b11) && (mRun >= limNear(l1Code)));
    it.l1 = !stopN;
    it.l2 = !stopB;
    it.tag = tag;
    expQ.push_back(it);
    reqValid = 1'b1;
    lineAddr = a;
    fullLine = full;
    @(negedge clk);
    reqValid = 1'b0;
    fullLine = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stream(input logic [ADDR_W-1:0] base, input int n, input string tag);
    for (int i = 0; i < n; i++) sendReq(base + ADDR_W'(i), 1'b1, tag);
  endtask

  // monitor: compare each decision with the scoreboard
  always @(negedge clk) begin
    if (!rst && outValid) begin
      expItem_t e;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1: decision with no request pending (actual outValid=1, expected 0)");
      end else begin
        e = expQ.pop_front();
        if (allocL1 !== e.l1 || allocL2 !== e.l2) begin
          errors++;
          $display("FAIL %s: allocL1/allocL2 actual %b%b expected %b%b",
                   e.tag, allocL1, allocL2, e.l1, e.l2);
        end
      end
    end
  end

  task automatic checkQuiet(input string tag);
    checks++;
    if (outValid !== 1'b0 || allocL1 !== 1'b0 || allocL2 !== 1'b0) begin
      errors++;
      $display("FAIL %s: outputs actual %b%b%b expected 000", tag, outValid, allocL1, allocL2);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0; lineAddr = '0; fullLine = 1'b0;
    l1Code = 2'b00; l2Code = 2'b01;
    modelReset();
    idle(3);
    checkQuiet("R11");
    rst = 1'b0;
    idle(1);
    checkQuiet("R2");

    // register reset values: near limit 4, both limit 128
    stream(40'h1000, 140, "R5 R6 default codes");
    // partial write breaks the run, next full write restarts at 1
    sendReq(40'h108C, 1'b0, "R4");
    stream(40'h108D, 6, "R8 restart after partial");
    // gap in addresses restarts
    stream(40'h1100, 3, "R8 gap");
    sendReq(40'h1102, 1'b1, "R8 repeat address");
    sendReq(40'h1101, 1'b1, "R8 lower address");
    // idle cycles inside a run do not break it
    sendReq(40'h1102, 1'b1, "R1");
    idle(3);
    sendReq(40'h1103, 1'b1, "R1");
    idle(2);
    sendReq(40'h1104, 1'b1, "R1 fourth after idle");

    l1Code = 2'b01; l2Code = 2'b00;
    stream(40'h2000, 20, "R5 limit 16");
    l1Code = 2'b01; l2Code = 2'b11;
    stream(40'h3000, 70, "R6 limit 64");
    l1Code = 2'b10; l2Code = 2'b11;
    stream(40'h4000, 132, "R6 limit 128 R7");
    l1Code = 2'b11; l2Code = 2'b11;
    stream(40'h5000, 20, "R7 both off");

    // code change mid run keeps the count
    stream(40'h6000, 10, "R10 before change");
    l1Code = 2'b00;
    stream(40'h600A, 2, "R10 after change");
    l2Code = 2'b00;
    stream(40'h600C, 8, "R10 both after change");

    // long run: saturation, no wrap
    l1Code = 2'b11; l2Code = 2'b10;
    stream(40'h10000, 1100, "R9 saturation");

    // reset forgets the run
    l1Code = 2'b00; l2Code = 2'b01;
    stream(40'h7000, 5, "R6");
    idle(2);
    rst = 1'b1;
    idle(2);
    checkQuiet("R11");
    rst = 1'b0;
    modelReset();
    stream(40'h7005, 4, "R11 run after reset");
    idle(4);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R1: pending decisions actual %0d expected 0", expQ.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule